// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block is the digital front end of a 10-bit current-steering digital-to-analog converter. On every rising clock edge it captures one sample code. It splits that code into three fields. The top five bits drive a thermometer-coded array of 31 equal coarse switches. The next four bits drive a thermometer-coded array of 15 equal middle switches, each worth one sixteenth of a coarse switch. The lowest bit drives one binary-weighted switch worth half a middle switch. The analog current cells, the reference and the output network are outside this block.

Each switch steers its unit current into one of two output nodes. For that reason every select comes out as a registered pair: a true select for node A and a complementary select for node B. All pairs are loaded in one final register stage, so every segment changes on the same clock edge. The converter takes one sample per clock and cannot stall. For that reason the data input has no valid/ready handshake: a new code is accepted on every edge.

Top module: `segdac_front`

## Requirements
- R1: A 10-bit code on `code_i` is accepted on every rising clock edge, and every value from 0 to 1023 is a legal input.
- R2: A code present before rising edge n appears on all switch outputs after rising edge n+1 (two cycles of latency). The outputs then hold until the next edge.
- R3: The coarse field is code bits [9:5]. Bit k of `coarse_a_o` (k = 0..30) is 1 exactly when that field is greater than k.
- R4: The middle field is code bits [4:1]. Bit k of `mid_a_o` (k = 0..14) is 1 exactly when that field is greater than k.
- R5: `lsb_a_o[0]` equals code bit 0.
- R6: Each B output is the bitwise complement of its matching A output in every cycle, including during reset.
- R7: Reset is synchronous and active high. At each edge with `rst` high, both register stages clear to code 0: all A selects go to 0 and all B selects go to 1. After reset is released, the outputs show code 0 until the first new code has gone through both stages.
- R8: Weight the A selects as 32 per coarse switch, 2 per middle switch and 1 for the low switch. That total equals the code from two edges earlier. The same weighting applied to the B selects equals 1023 minus that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 10 | Sample code, unsigned |
| coarse_a_o | output | 31 | Coarse thermometer selects toward node A |
| coarse_b_o | output | 31 | Complementary coarse selects toward node B |
| mid_a_o | output | 15 | Middle thermometer selects toward node A |
| mid_b_o | output | 15 | Complementary middle selects toward node B |
| lsb_a_o | output | 1 | Binary low switch select toward node A |
| lsb_b_o | output | 1 | Complementary low switch select toward node B |

## Verification
A wrong input register or a wrong field boundary shows up within two cycles as a weighted A total that differs from the code. A wrong field boundary of this kind is off by a whole coarse or middle step. A thermometer decoder off by one level leaves a gap or an extra select in one array. That error shows up as a non-contiguous pattern or a total that is off by one unit of that array. A lost or overlapping complement shows up at once as a B total that no longer equals 1023 minus the A total. The sweeps cover every code in rising order, in falling order, at large jumps and in pseudo-random order. A reset in mid-stream shows whether both stages clear on the same edge.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int SEGDAC_CODE_W = 10;
  localparam int SEGDAC_HI_W   = 5;
  localparam int SEGDAC_MID_W  = 4;

  function automatic int therm_len(input int field_w);
    return (1 << field_w) - 1;
  endfunction
endpackage

// File: rtl/segdac_in_reg.sv
module segdac_in_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

  // R7: the capture stage clears on a reset edge
  assert_in_clear_R7: assert property (@(posedge clk) rst |=> (q_o == '0));
endmodule

// File: rtl/segdac_thermo_dec.sv
module segdac_thermo_dec #(
  parameter int IN_W = 5,
  localparam int N   = (1 << IN_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] value_i,
  output logic [N-1:0]    therm_o
);
  for (genvar k = 0; k < N; k++) begin : g_level
    assign therm_o[k] = (value_i > IN_W'(k));
  end

  // R3/R4: the number of raised selects equals the field value
  assert_therm_count_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_o) == int'(value_i));
  // R4: the raised selects form one unbroken run starting at bit 0
  assert_therm_contig_R4: assert property (@(posedge clk) disable iff (rst)
    ((therm_o & (therm_o + N'(1))) == '0));
endmodule

// File: rtl/segdac_pair_reg.sv
module segdac_pair_reg #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_o <= '0;
      b_o <= '1;
    end else begin
      a_o <= sel_i;
      b_o <= ~sel_i;
    end
  end

  // R6: the two selects of every switch stay complementary
  assert_pair_compl_R6: assert property (@(posedge clk) disable iff (rst)
    ((a_o ^ b_o) == '1));
  // R7: a reset edge parks every switch on node B
  assert_pair_reset_R7: assert property (@(posedge clk)
    rst |=> ((a_o == '0) && (b_o == '1)));
  // R2: the pair follows its select input one edge later
  assert_pair_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_o == $past(sel_i)));
endmodule

// File: rtl/segdac_front.sv
module segdac_front #(
  parameter int CODE_W = segdac_pkg::SEGDAC_CODE_W,
  parameter int HI_W   = segdac_pkg::SEGDAC_HI_W,
  parameter int MID_W  = segdac_pkg::SEGDAC_MID_W,
  localparam int LO_W  = CODE_W - HI_W - MID_W,
  localparam int HI_N  = (1 << HI_W) - 1,
  localparam int MID_N = (1 << MID_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic [HI_N-1:0]   coarse_a_o,
  output logic [HI_N-1:0]   coarse_b_o,
  output logic [MID_N-1:0]  mid_a_o,
  output logic [MID_N-1:0]  mid_b_o,
  output logic [LO_W-1:0]   lsb_a_o,
  output logic [LO_W-1:0]   lsb_b_o
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int W_HI     = 1 << (MID_W + LO_W);
  localparam int W_MID    = 1 << LO_W;

  logic [CODE_W-1:0] code_q;
  logic [HI_W-1:0]   hi_field;
  logic [MID_W-1:0]  mid_field;
  logic [LO_W-1:0]   lo_field;
  logic [HI_N-1:0]   hi_therm;
  logic [MID_N-1:0]  mid_therm;

  segdac_in_reg #(.W(CODE_W)) u_in (
    .clk(clk), .rst(rst), .d_i(code_i), .q_o(code_q));

  assign hi_field  = code_q[CODE_W-1 -: HI_W];
  assign mid_field = code_q[LO_W +: MID_W];
  assign lo_field  = code_q[LO_W-1:0];

  segdac_thermo_dec #(.IN_W(HI_W)) u_hi_dec (
    .clk(clk), .rst(rst), .value_i(hi_field), .therm_o(hi_therm));
  segdac_thermo_dec #(.IN_W(MID_W)) u_mid_dec (
    .clk(clk), .rst(rst), .value_i(mid_field), .therm_o(mid_therm));

  segdac_pair_reg #(.W(HI_N)) u_hi_out (
    .clk(clk), .rst(rst), .sel_i(hi_therm), .a_o(coarse_a_o), .b_o(coarse_b_o));
  segdac_pair_reg #(.W(MID_N)) u_mid_out (
    .clk(clk), .rst(rst), .sel_i(mid_therm), .a_o(mid_a_o), .b_o(mid_b_o));
  segdac_pair_reg #(.W(LO_W)) u_lo_out (
    .clk(clk), .rst(rst), .sel_i(lo_field), .a_o(lsb_a_o), .b_o(lsb_b_o));

  // Checker-only: count clean edges since reset and form weighted totals
  logic [1:0] fill_q;
  int         a_total, b_total;
  always_ff @(posedge clk) begin
    if (rst)                fill_q <= '0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end
  always_comb begin
    a_total = W_HI * $countones(coarse_a_o) + W_MID * $countones(mid_a_o) + int'(lsb_a_o);
    b_total = W_HI * $countones(coarse_b_o) + W_MID * $countones(mid_b_o) + int'(lsb_b_o);
  end

  // R2/R8: the A total matches the code from two edges back
  assert_a_total_R8: assert property (@(posedge clk) disable iff (rst)
    (fill_q == 2'd2) |-> (a_total == int'($past(code_i, 2))));
  // R8: the B total carries the remainder of full scale
  assert_b_total_R8: assert property (@(posedge clk) disable iff (rst)
    (fill_q == 2'd2) |-> (b_total == CODE_MAX - int'($past(code_i, 2))));
  // R5: the low switch follows bit 0 of the captured code
  assert_lsb_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_q != 2'd0) |=> (lsb_a_o == $past(code_q[LO_W-1:0])));
endmodule

// File: tb/segdac_front_tb.sv
module segdac_front_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] code = '0;
  logic [30:0] coarse_a, coarse_b;
  logic [14:0] mid_a, mid_b;
  logic [0:0]  lsb_a, lsb_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  int ms1 = 0, ms2 = 0, prev_code = 0;
  bit prev_rst = 1'b1;
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  segdac_front dut_i (
    .clk(clk), .rst(rst), .code_i(code),
    .coarse_a_o(coarse_a), .coarse_b_o(coarse_b),
    .mid_a_o(mid_a), .mid_b_o(mid_b),
    .lsb_a_o(lsb_a), .lsb_b_o(lsb_b));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input bit after_rst);
    longint exp_c, exp_m;
    int wa, wb;
    exp_c = (longint'(1) << (ms2 >> 5)) - 1;
    exp_m = (longint'(1) << ((ms2 >> 1) & 15)) - 1;
    wa = 32 * $countones(coarse_a) + 2 * $countones(mid_a) + int'(lsb_a);
    wb = 32 * $countones(coarse_b) + 2 * $countones(mid_b) + int'(lsb_b);
    chk(coarse_a == 31'(exp_c), "R3 coarse thermometer", coarse_a, exp_c);
    chk(mid_a == 15'(exp_m), "R4 middle thermometer", mid_a, exp_m);
    chk(lsb_a[0] == ms2[0], "R5 low bit", lsb_a, ms2 & 1);
    chk(((coarse_a ^ coarse_b) == '1) && ((mid_a ^ mid_b) == '1) && ((lsb_a ^ lsb_b) == '1),
        "R6 complement pairs", {coarse_b, mid_b, lsb_b}, ~{coarse_a, mid_a, lsb_a});
    chk(wa == ms2, "R1 R2 R8 A-side total", wa, ms2);
    chk(wb == 1023 - ms2, "R8 B-side total", wb, 1023 - ms2);
    if (after_rst)
      chk((coarse_a == '0) && (mid_a == '0) && (coarse_b == '1) && (mid_b == '1),
          "R7 reset state", {coarse_a, mid_a}, 0);
  endtask

  task automatic step(input bit r, input int c);
    bit was_rst;
    @(negedge clk);
    was_rst = prev_rst;
    ms2 = prev_rst ? 0 : ms1;
    ms1 = prev_rst ? 0 : prev_code;
    check_outputs(was_rst);
    rst = r;
    code = c[9:0];
    prev_rst = r;
    prev_code = c & 1023;
  endtask

  initial begin
    step(1, 1023);
    step(1, 1023);
    step(0, 1023);
    for (int i = 0; i < 1024; i++) step(0, i);            // rising sweep
    for (int i = 1023; i >= 0; i--) step(0, i);           // falling sweep
    for (int i = 0; i < 32; i++) step(0, (i % 2) ? 1023 : 0);
    step(0, 31); step(0, 32); step(0, 511); step(0, 512); step(0, 30); step(0, 33);
    step(0, 700);
    step(1, 900);                                          // mid-stream reset (R7)
    step(0, 900);
    step(0, 5);
    for (int i = 0; i < 600; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step(0, int'(lcg[25:16]));
    end
    step(0, 0); step(0, 0); step(0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule